// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits beside a free-running timer counter and records the counter value when a chosen edge appears on one of three event sources. Source 1 is an external pin. Source 2 is the level output of an on-chip comparator. Source 3 is that comparator's edge output. Every source passes through a synchroniser and then an edge detector. A qualifying edge copies the counter into the capture register of that channel and sets the channel's sticky event flag.

Software sets up the unit through a small register window. One control word holds a three-bit group for each channel: rising-edge enable, falling-edge enable and interrupt enable. A flag word is cleared by writing ones to it. Three read-only words return the captured values. The interrupt line is high while any flag is set whose channel has its interrupt enable set. The counter, prescaler, match logic and bus fabric lie outside this block. The register window is a plain control path and has no handshake, so it applies no back-pressure. A read returns data in the same cycle. A write takes effect at the next clock edge.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset, the control word, the flag word and all three capture words read 0, and `irq` is low.
- R2: The control word is at address 0. Channel n (1..3) uses bits 3n+2:3n, with the rising-edge enable at bit 3n, the falling-edge enable at bit 3n+1 and the interrupt enable at bit 3n+2. Bits 2:0 and 31:12 always read 0, whatever was written to them.
- R3: Channel 1 is fed from `cap_pin`, channel 2 from `cmp_level` and channel 3 from `cmp_edge`. A transition on one source never changes the capture word or the flag of another channel.
- R4: With the rising-edge enable set, a 0-to-1 change on a source loads that channel's capture word with the `tc_value` present just before the third rising clock edge after the change. That load happens at that third edge.
- R5: With the falling-edge enable set, a 1-to-0 change loads the capture word with the same timing as R4.
- R6: With both edge enables set, a capture happens on every change. With neither set, the channel never captures and its capture word holds its value.
- R7: The flag word is at address 1, with bit n-1 for channel n. Each capture sets the flag, and the flag stays set until software writes 1 to that bit. If a capture and a clear fall in the same cycle, the flag stays set.
- R8: `irq` is high exactly when some channel has both its flag and its interrupt enable set. A flag still sets while its interrupt enable is clear, so setting the enable later raises `irq` at once.
- R9: The capture words are at addresses 4, 5 and 6 for channels 1, 2 and 3, zero-extended to 32 bits. Writes to them are ignored. A new capture overwrites the old value even if it has not been read.
- R10: Addresses 2, 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_value | input | CNT_W | Current value of the free-running timer counter |
| cap_pin | input | 1 | External pin, source of channel 1 |
| cmp_level | input | 1 | Comparator level output, source of channel 2 |
| cmp_edge | input | 1 | Comparator edge output, source of channel 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter and two synchroniser stages. Its reference model assumes the three-edge capture latency that these defaults give. The counter starts close to its top value, so captures are taken on both sides of the wrap from all ones to zero. This shows that the full width is stored unchanged. A 16-bit counter also keeps the zero-extension of the capture words visible in the upper read bits.

The directed phases cover captures that overlap a flag clear in the same cycle. They also cover writes to the read-only capture words and edges on sources whose channel is disabled. A random phase follows, which mixes control writes, flag clears and toggling sources.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int NCH     = 3;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int GRP_W   = 3;
  localparam int GRP_LSB = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAP1 = 3'd4;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } chan_cfg_t;

  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NCH; k++) m[GRP_LSB + GRP_W*k +: GRP_W] = '1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();
endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;
  logic              s_out;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign s_out = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= s_out;
  end

  assign rise = s_out & ~last_q;
  assign fall = ~s_out & last_q;
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  chan_cfg_t        cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  output logic             hit,
  output logic [CNT_W-1:0] cap,
  output logic             flag
);
  assign hit = (rise & cfg.rise_en) | (fall & cfg.fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      flag <= 1'b0;
    end else begin
      if (hit) cap <= cnt;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tc_value,
  input  logic              cap_pin,
  input  logic              cmp_level,
  input  logic              cmp_edge,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [REG_W-1:0]     ctrl_q;
  logic [NCH-1:0]       src;
  logic [NCH-1:0]       rise;
  logic [NCH-1:0]       fall;
  logic [NCH-1:0]       hit;
  logic [NCH-1:0]       flag;
  logic [NCH-1:0]       clr;
  logic [NCH-1:0]       ie;
  logic [CNT_W-1:0]     cap [NCH];
  logic [NCH*CNT_W-1:0] cap_flat;
  chan_cfg_t            cfg [NCH];

  assign src = {cmp_edge, cmp_level, cap_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
  end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign cfg[k] = chan_cfg_t'(ctrl_q[GRP_LSB + GRP_W*k +: GRP_W]);
      assign ie[k]  = cfg[k].irq_en;
      assign clr[k] = reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[k];

      tcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src[k]),
        .rise (rise[k]),
        .fall (fall[k])
      );

      tcap_channel #(.CNT_W(CNT_W)) u_chan (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (rise[k]),
        .fall (fall[k]),
        .cfg  (cfg[k]),
        .cnt  (tc_value),
        .clr  (clr[k]),
        .hit  (hit[k]),
        .cap  (cap[k]),
        .flag (flag[k])
      );

      assign cap_flat[k*CNT_W +: CNT_W] = cap[k];
    end
  endgenerate

  assign irq = |(flag & ie);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata = ctrl_q;
    end else if (reg_addr == ADDR_FLAG) begin
      reg_rdata[NCH-1:0] = flag;
    end else begin
      for (int k = 0; k < NCH; k++)
        if (reg_addr == ADDR_CAP1 + ADDR_W'(k)) reg_rdata[CNT_W-1:0] = cap[k];
    end
  end
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq,
  input logic [31:0]      ctrl,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   flag,
  input logic [NCH*CNT_W-1:0] caps
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[31:12] == 20'd0 && reg_rdata[2:0] == 3'd0));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[5] && !ctrl[8] && !ctrl[11]) |-> !irq);

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_k
      // R7
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[k] |=> flag[k]);

      // R7
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[k] && !(reg_wr && reg_addr == 3'd1 && reg_wdata[k])) |=> flag[k]);

      // R9
      cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[k] |=> $stable(caps[k*CNT_W +: CNT_W]));

      // R6
      disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[3+3*k] && !ctrl[4+3*k]) |=> $stable(caps[k*CNT_W +: CNT_W]));
    end
  endgenerate
endmodule

bind tmr_capture_unit tcap_checker #(.CNT_W(CNT_W), .NCH(tcap_pkg::NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .ctrl     (ctrl_q),
  .hit      (hit),
  .flag     (flag),
  .caps     (cap_flat)
);

// File: tb/tmr_capture_unit_test.sv
module tmr_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tc_value = 16'hFFC0;
  logic        cap_pin = 1'b0, cmp_level = 1'b0, cmp_edge = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #10 clk = ~clk;

  tmr_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .tc_value(tc_value), .cap_pin(cap_pin),
    .cmp_level(cmp_level), .cmp_edge(cmp_edge), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string req = "R1";

  // reference model state
  logic [31:0] m_ctrl;
  logic [2:0]  m_flag;
  logic [15:0] m_cap [3];
  bit          h1 [3], h2 [3], h3 [3];

  always @(negedge clk) tc_value <= tc_value + 16'd1;

  function automatic bit src_of(int k);
    if (k == 0) return cap_pin;
    if (k == 1) return cmp_level;
    return cmp_edge;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:    return m_ctrl;
      3'd1:    return {29'd0, m_flag};
      3'd4:    return {16'd0, m_cap[0]};
      3'd5:    return {16'd0, m_cap[1]};
      3'd6:    return {16'd0, m_cap[2]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic r, f, hit, ie_any;
    if (!rst_n) begin
      m_ctrl = '0;
      m_flag = '0;
      for (int k = 0; k < 3; k++) begin
        m_cap[k] = '0; h1[k] = 0; h2[k] = 0; h3[k] = 0;
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        r   = h2[k] && !h3[k];
        f   = !h2[k] && h3[k];
        hit = (r && m_ctrl[3+3*k]) || (f && m_ctrl[4+3*k]);
        if (hit) begin
          m_cap[k]  = tc_value;
          m_flag[k] = 1'b1;
        end else if (reg_wr && reg_addr == 3'd1 && reg_wdata[k]) begin
          m_flag[k] = 1'b0;
        end
      end
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata & 32'h0000_0FF8;
      for (int k = 0; k < 3; k++) begin
        h3[k] = h2[k]; h2[k] = h1[k]; h1[k] = src_of(k);
      end
    end
    #5;
    if (!done) begin
      ie_any = (m_flag[0] && m_ctrl[5]) || (m_flag[1] && m_ctrl[8]) || (m_flag[2] && m_ctrl[11]);
      vectors++;
      if (reg_rdata !== exp_read(reg_addr)) begin
        fails++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", req, reg_addr, reg_rdata, exp_read(reg_addr));
      end
      vectors++;
      if (irq !== ie_any) begin
        fails++;
        $display("FAIL %s (irq, R8) actual=%b expected=%b", req, irq, ie_any);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1: reset values
    req = "R1";
    reg_addr = 3'd0; cyc(1);
    reg_addr = 3'd1; cyc(1);
    reg_addr = 3'd4; cyc(1);
    reg_addr = 3'd5; cyc(1);
    reg_addr = 3'd6; cyc(1);
    // R2: layout and reserved bits
    req = "R2";
    wr(3'd0, 32'hFFFF_FFFF); reg_addr = 3'd0; cyc(2);
    wr(3'd0, 32'h8000_0A5F); reg_addr = 3'd0; cyc(2);
    wr(3'd0, 32'h0);         reg_addr = 3'd0; cyc(1);
    // R4: rising capture on the pin
    req = "R4";
    wr(3'd0, 32'h28); reg_addr = 3'd4;
    cap_pin = 1'b1; cyc(6);
    cap_pin = 1'b0; cyc(6);
    // R5: falling capture
    req = "R5";
    wr(3'd0, 32'h30); reg_addr = 3'd4;
    cap_pin = 1'b1; cyc(5);
    cap_pin = 1'b0; cyc(6);
    // R3: comparator sources, pin isolated
    req = "R3";
    wr(3'd1, 32'h7);
    wr(3'd0, 32'hFC0); reg_addr = 3'd5;
    cmp_level = 1'b1; cyc(6);
    cap_pin = 1'b1; cyc(5);
    cmp_level = 1'b0; cyc(6);
    reg_addr = 3'd6;
    cmp_edge = 1'b1; cyc(1);
    cmp_edge = 1'b0; cyc(6);
    reg_addr = 3'd4; cap_pin = 1'b0; cyc(5);
    reg_addr = 3'd1; cyc(1);
    // R6: both edges on ch1, none on ch2
    req = "R6";
    wr(3'd0, 32'h18);
    for (int i = 0; i < 8; i++) begin
      cap_pin = ~cap_pin; cmp_level = ~cmp_level;
      reg_addr = (i % 2 == 0) ? 3'd4 : 3'd5;
      cyc(4);
    end
    // R7: clears colliding with captures
    req = "R7";
    wr(3'd1, 32'h7); wr(3'd0, 32'h18);
    for (int i = 0; i < 36; i++) begin
      if (i % 3 == 0) cap_pin = ~cap_pin;
      reg_addr = 3'd1; reg_wdata = 32'h1; reg_wr = (i % 2 == 0);
      cyc(1);
    end
    reg_wr = 1'b0; cyc(4);
    // R8: flag without enable, then enable
    req = "R8";
    wr(3'd1, 32'h7); wr(3'd0, 32'h18); reg_addr = 3'd1;
    cap_pin = ~cap_pin; cyc(6);
    wr(3'd0, 32'h38); reg_addr = 3'd1; cyc(3);
    wr(3'd1, 32'h1); cyc(2);
    // R9: capture words are read-only, overwritten by new captures
    req = "R9";
    wr(3'd4, 32'hFFFF_FFFF); reg_addr = 3'd4; cyc(1);
    wr(3'd5, 32'h1234_5678); reg_addr = 3'd5; cyc(1);
    wr(3'd6, 32'hDEAD_BEEF); reg_addr = 3'd6; cyc(1);
    reg_addr = 3'd4;
    cap_pin = ~cap_pin; cyc(6);
    cap_pin = ~cap_pin; cyc(6);
    // R10: unmapped addresses
    req = "R10";
    reg_addr = 3'd2; cyc(1);
    reg_addr = 3'd3; cyc(1);
    reg_addr = 3'd7; cyc(1);
    // mixed random traffic across R3, R6, R7, R8
    req = "R7 random";
    for (int i = 0; i < 600; i++) begin
      cap_pin   = ($urandom % 3 == 0) ? ~cap_pin : cap_pin;
      cmp_level = ($urandom % 4 == 0) ? ~cmp_level : cmp_level;
      cmp_edge  = ($urandom % 5 == 0);
      reg_addr  = 3'($urandom);
      reg_wdata = $urandom;
      reg_wr    = ($urandom % 6 == 0);
      cyc(1);
    end
    reg_wr = 1'b0;
    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule